// File: doc/BRIEF.md
# Two-Step Column ADC Sequencer with Digital Correlated Double Sampling

This block is the digital controller behind one column converter of an image sensor. For each pixel it first measures the pixel's reset level with a single-slope ramp alone, then measures the pixel's signal level in two steps: a 5-bit successive-approximation search on a capacitor DAC, followed by a 7-bit single-slope ramp on the residue. The difference between the two ramp measurements removes the pixel's reset offset in the digital domain.

Both ramp measurements share one 8-bit counter that can only count down. The counter is cleared before the reset ramp, and its bits are inverted between the two ramps. A last inversion leaves the signed fine difference, and the extra top bit lets that difference cross a coarse step boundary. A subtracter stage adds this difference to the coarse code scaled by 128. It clamps the sum to the 12-bit output range and presents it with a one-cycle completion strobe. The comparator, DAC, sampling switch and ramp generator are analog parts outside the block. The block reads only the comparator's decision bit and drives the DAC code, the ramp enable and the level select.

Top module: `cds_twostep_adc`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block returns to idle: done_o, busy_o, ramp_en_o, samp_sel_o, dac_code_o and result_o are all 0.
- R2: A start_i pulse in idle begins with the reset-level ramp. During that ramp samp_sel_o is 0 and dac_code_o is 0, and there is no coarse search for the reset level.
- R3: In each ramp, the fine count goes down by one on every clock with cmp_i = 1. The ramp ends on the first clock with cmp_i = 0, or after 127 counts. This makes ramp_en_o high for min(N,127)+1 clocks, where N is the number of leading clocks with cmp_i = 1.
- R4: After the reset ramp, the coarse search takes exactly 5 clocks with samp_sel_o = 1 and ramp_en_o = 0. It tests dac_code_o bits from bit 4 down to bit 0 and keeps a trial bit when cmp_i = 1 (input at or above the DAC level).
- R5: During the signal ramp (samp_sel_o = 1, ramp_en_o = 1), dac_code_o holds the final coarse code unchanged.
- R6: result_o = coarse_code*128 + (signal fine count - reset fine count), clamped to 0..4095. A negative fine difference may pull the result below coarse_code*128.
- R7: done_o is high for exactly one clock per conversion, with result_o valid in that clock. In the following clock both done_o and busy_o are 0.
- R8: A start_i that arrives while busy_o is 1 is ignored. It does not restart, extend or queue a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a conversion (taken only in idle) |
| cmp_i | input | 1 | Comparator decision: 1 while the input is at or above the DAC/ramp level |
| samp_sel_o | output | 1 | 0 selects the pixel reset level, 1 the pixel signal level |
| ramp_en_o | output | 1 | Runs the single-slope ramp |
| dac_code_o | output | 5 | Coarse capacitor-DAC code |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle strobe: result_o is valid |
| result_o | output | 12 | Corrected, clamped conversion result |

## Verification
A wrong counter state cannot be seen until the done strobe. It then shows as a result that is off by the reset count, or off by one when an inversion is missed. A wrong step count shows earlier, as a ramp window whose length does not match the comparator pattern. A wrong coarse register shows at once on dac_code_o, during the 5 search clocks or as a code that moves during the signal ramp. A sequencer that leaves a wrong state shows as a missing, doubled or wide done strobe, or as busy_o held high until the watchdog expires.

// File: rtl/cds_pkg.sv
// Shared types of the column converter controller.
// Assumes: nothing beyond IEEE 1800-2017.
package cds_pkg;

    // Conversion sequence; order follows the measurement order.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_RAMP,
        ST_FLIP,
        ST_COARSE,
        ST_SIG_RAMP,
        ST_CALC
    } cds_state_e;

endpackage

// File: rtl/cds_sar_search.sv
// Coarse successive-approximation register.
// Tests one bit per clock from the MSB downward. It keeps a trial bit when
// the comparator says the input is at or above the DAC level.
// Assumes: load precedes step, and step is held for exactly BITS clocks.
module cds_sar_search #(
    parameter int BITS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            load,
    input  logic            step,
    input  logic            cmp_i,
    output logic [BITS-1:0] code_o,
    output logic            last_o
);
    localparam int IW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [IW-1:0] TOP_IDX = IW'(BITS - 1);

    logic [BITS-1:0] code_q, code_d;
    logic [IW-1:0]   idx_q;

    // Next trial code: settle the bit under test, raise the next one.
    always_comb begin
        code_d = code_q;
        if (!cmp_i) code_d[idx_q] = 1'b0;
        if (idx_q != '0) code_d[idx_q - 1'b1] = 1'b1;
    end

    // Code and bit-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            code_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            code_q <= {1'b1, {(BITS-1){1'b0}}};
            idx_q  <= TOP_IDX;
        end else if (step) begin
            code_q <= code_d;
            if (idx_q != '0) idx_q <= idx_q - 1'b1;
        end
    end

    assign code_o = code_q;
    assign last_o = (idx_q == '0);

    // R4: the search stops right after its last bit.
    p_coarse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_o) |=> !step);

    // R4: a load always presents the MSB trial.
    p_load_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (code_o == {1'b1, {(BITS-1){1'b0}}}));
endmodule

// File: rtl/cds_down_counter.sv
// Down-only fine counter with one redundant top bit, plus a ramp step
// counter that caps each ramp at 2**FINE_BITS-1 counts.
// Assumes: clear before the reset ramp and flip between the two ramps.
module cds_down_counter #(
    parameter int FINE_BITS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               flip,
    input  logic               dec,
    output logic [FINE_BITS:0] cnt_o,
    output logic               cap_o
);
    localparam int W = FINE_BITS + 1;
    localparam logic [FINE_BITS-1:0] STEP_MAX = {FINE_BITS{1'b1}};

    logic [W-1:0]         cnt_q;
    logic [FINE_BITS-1:0] steps_q;

    // Counter and step registers: clear, invert between phases, or count down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q   <= '0;
            steps_q <= '0;
        end else if (flip) begin
            cnt_q   <= ~cnt_q;
            steps_q <= '0;
        end else if (dec) begin
            cnt_q   <= cnt_q - 1'b1;
            steps_q <= steps_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign cap_o = (steps_q == STEP_MAX);

    // R3: each enabled clock lowers the count by exactly one.
    p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clear && !flip) |=> (cnt_o == $past(cnt_o) - 1'b1));

    // R3: the sequencer never counts past the ramp cap.
    p_no_count_past_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !cap_o);
endmodule

// File: rtl/cds_combine.sv
// Subtracter stage: coarse code scaled by 2**FINE_BITS plus the signed fine
// difference (bitwise inverse of the counter), clamped to OUT_W bits.
// Assumes: OUT_W == COARSE_BITS + FINE_BITS.
module cds_combine #(
    parameter int COARSE_BITS = 5,
    parameter int FINE_BITS   = 7,
    parameter int OUT_W       = 12
) (
    input  logic [COARSE_BITS-1:0] coarse_i,
    input  logic [FINE_BITS:0]     cnt_i,
    output logic [OUT_W-1:0]       result_o
);
    localparam int W  = FINE_BITS + 1;
    localparam int SW = OUT_W + 2;
    localparam logic signed [SW-1:0] MAXV = SW'((2 ** OUT_W) - 1);

    logic [W-1:0]         diff;
    logic signed [SW-1:0] base, delta, sum;

    // Final inversion, widening and clamping of the sum.
    always_comb begin
        diff  = ~cnt_i;
        base  = $signed({2'b00, coarse_i, {FINE_BITS{1'b0}}});
        delta = $signed({{(SW-W){diff[W-1]}}, diff});
        sum   = base + delta;
        if (sum < 0)         result_o = '0;
        else if (sum > MAXV) result_o = MAXV[OUT_W-1:0];
        else                 result_o = sum[OUT_W-1:0];
    end
endmodule

// File: rtl/cds_twostep_adc.sv
// Sequencer of one column conversion with digital correlated double sampling.
// Order: reset-level ramp, counter inversion, coarse search on the signal,
// signal ramp, result. Drives DAC code, ramp enable and level select, and
// reads one comparator bit.
// Assumes: cmp_i is already synchronous to clk.
module cds_twostep_adc
    import cds_pkg::*;
#(
    parameter int COARSE_BITS = 5,
    parameter int FINE_BITS   = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         cmp_i,
    output logic                         samp_sel_o,
    output logic                         ramp_en_o,
    output logic [COARSE_BITS-1:0]       dac_code_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [COARSE_BITS+FINE_BITS-1:0] result_o
);
    localparam int OUT_W = COARSE_BITS + FINE_BITS;

    cds_state_e          state_q, state_d;
    logic                ramp_stop, dec, cnt_clear, cnt_flip;
    logic                sar_load, sar_step, sar_last, cap_hit;
    logic [FINE_BITS:0]  cnt;
    logic [OUT_W-1:0]    sum_clamped;

    // Phase decodes and ramp termination.
    always_comb begin
        ramp_en_o  = (state_q == ST_RST_RAMP) || (state_q == ST_SIG_RAMP);
        samp_sel_o = (state_q == ST_COARSE) || (state_q == ST_SIG_RAMP);
        busy_o     = (state_q != ST_IDLE);
        ramp_stop  = !cmp_i || cap_hit;
        dec        = ramp_en_o && !ramp_stop;
        cnt_clear  = (state_q == ST_IDLE) && start_i;
        cnt_flip   = (state_q == ST_FLIP);
        sar_load   = (state_q == ST_FLIP);
        sar_step   = (state_q == ST_COARSE);
    end

    // Next-state selection of the conversion sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (start_i)   state_d = ST_RST_RAMP;
            ST_RST_RAMP: if (ramp_stop) state_d = ST_FLIP;
            ST_FLIP:                    state_d = ST_COARSE;
            ST_COARSE:   if (sar_last)  state_d = ST_SIG_RAMP;
            ST_SIG_RAMP: if (ramp_stop) state_d = ST_CALC;
            ST_CALC:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result register and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= (state_q == ST_CALC);
            if (state_q == ST_CALC) result_o <= sum_clamped;
        end
    end

    cds_sar_search #(.BITS(COARSE_BITS)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .load   (sar_load),
        .step   (sar_step),
        .cmp_i  (cmp_i),
        .code_o (dac_code_o),
        .last_o (sar_last)
    );

    cds_down_counter #(.FINE_BITS(FINE_BITS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .flip  (cnt_flip),
        .dec   (dec),
        .cnt_o (cnt),
        .cap_o (cap_hit)
    );

    cds_combine #(
        .COARSE_BITS (COARSE_BITS),
        .FINE_BITS   (FINE_BITS),
        .OUT_W       (OUT_W)
    ) u_comb (
        .coarse_i (dac_code_o),
        .cnt_i    (cnt),
        .result_o (sum_clamped)
    );

    // R2: no coarse code is applied while the reset level is ramped.
    p_reset_dac_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en_o && !samp_sel_o) |-> (dac_code_o == '0));

    // R5: the coarse code is frozen during the signal ramp.
    p_sig_dac_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en_o && samp_sel_o) |=> (!ramp_en_o || $stable(dac_code_o)));

    // R7: the completion strobe lasts a single clock and ends the conversion.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8: a start during a conversion does not drop or restart it.
    p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q != ST_CALC) |=> busy_o);

    // R4: the coarse search always follows the inversion step.
    p_flip_then_coarse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLIP) |=> (samp_sel_o && !ramp_en_o));
endmodule

// File: tb/sim_cds_twostep_adc.sv
// Bench: models the comparator, DAC and ramp. Runs directed and seeded
// random conversions and compares against values computed from the requirements.
module sim_cds_twostep_adc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmp;
    logic        samp_sel, ramp_en, busy, done;
    logic [4:0]  dac;
    logic [11:0] result;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int vin  = 0;   // signal level in fine LSBs
    int rlev = 0;   // reset level in fine LSBs
    int k    = 0;   // analog ramp position

    always #2 clk = ~clk;

    cds_twostep_adc u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
        .samp_sel_o(samp_sel), .ramp_en_o(ramp_en), .dac_code_o(dac),
        .busy_o(busy), .done_o(done), .result_o(result)
    );

    // Ramp rises one LSB per clock while enabled, and falls back when idle.
    always @(negedge clk) begin
        if (ramp_en) k <= k + 1;
        else         k <= 0;
    end

    // Comparator: ramp versus the selected level, or input versus DAC.
    always_comb begin
        if (ramp_en)
            cmp = (k <= (samp_sel ? (vin - int'(dac) * 128) : rlev));
        else
            cmp = (vin >= int'(dac) * 128);
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_coarse(input int v);
        int c = v / 128;
        return (c > 31) ? 31 : c;
    endfunction

    function automatic int cap127(input int x);
        return (x > 127) ? 127 : x;
    endfunction

    function automatic int exp_result(input int v, input int r);
        int c = exp_coarse(v);
        int s = c * 128 + cap127(v - c * 128) - cap127(r);
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        return s;
    endfunction

    task automatic convert(input int v, input int r, input bit inject);
        int n_rst = 0, n_crs = 0, n_sig = 0, n_done = 0;
        int dac_sig = -1;
        bit dac_bad = 0, dac_moved = 0, got = 0;
        int c_exp = exp_coarse(v);
        vin = v; rlev = r;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int n = 0; n < 2000; n++) begin
            if (ramp_en && !samp_sel) begin
                n_rst++;
                if (dac != 5'd0) dac_bad = 1;
            end
            if (samp_sel && !ramp_en) n_crs++;
            if (ramp_en && samp_sel) begin
                n_sig++;
                if (dac_sig < 0) dac_sig = int'(dac);
                else if (int'(dac) != dac_sig) dac_moved = 1;
            end
            start = (inject && n == 3);
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        start = 1'b0;
        chk(got, "R7", "done seen", int'(got), 1);
        chk(int'(result) == exp_result(v, r), "R6", "result", int'(result), exp_result(v, r));
        chk(!dac_bad, "R2", "dac zero in reset ramp", int'(dac_bad), 0);
        chk(n_rst == cap127(r) + 1, "R3", "reset ramp clocks", n_rst, cap127(r) + 1);
        chk(n_crs == 5, "R4", "coarse clocks", n_crs, 5);
        chk(dac_sig == c_exp, "R4", "coarse code", dac_sig, c_exp);
        chk(!dac_moved, "R5", "dac held in signal ramp", int'(dac_moved), 0);
        chk(n_sig == cap127(v - c_exp * 128) + 1, "R3", "signal ramp clocks",
            n_sig, cap127(v - c_exp * 128) + 1);
        @(negedge clk);
        chk(!done && !busy, "R7", "strobe width", int'(done) + int'(busy), 0);
        if (inject) begin
            for (int n = 0; n < 8; n++) begin
                if (done || busy) n_done++;
                @(negedge clk);
            end
            chk(n_done == 0, "R8", "no restart after ignored start", n_done, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240812));
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held.
        chk(!done && !busy && !ramp_en && !samp_sel && dac == 5'd0 && result == 12'd0,
            "R1", "reset state", int'(result) + int'(dac) + int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        convert(0, 0, 0);          // both levels at zero
        convert(0, 50, 0);         // R6 clamp at zero
        convert(4095, 0, 0);       // full scale
        convert(5000, 0, 0);       // R3 signal ramp cap, R6 upper end
        convert(650, 30, 0);       // R6 difference crosses a coarse boundary
        convert(300, 200, 0);      // R3 reset ramp cap
        convert(1280, 0, 1);       // R8 start during conversion
        convert(127, 127, 1);      // R8 with full fine counts
        for (int i = 0; i < 20; i++)
            convert(int'($urandom_range(0, 4300)), int'($urandom_range(0, 140)), (i % 5) == 0);
        // R1: reset in the middle of a conversion returns to idle.
        vin = 2000; rlev = 20;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !ramp_en && !samp_sel && dac == 5'd0 && !done,
            "R1", "mid-run reset", int'(busy) + int'(dac), 0);
        rst_n = 1'b1;
        @(negedge clk);
        convert(2000, 20, 0);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule